// File: doc/BRIEF.md
# SCSI Initiator Byte Handshake Engine

This block is the bus-facing half of a parallel SCSI initiator. A controlling sequencer hands it a byte count and the information-transfer phase it expects, and the engine then moves that many bytes one at a time with the asynchronous REQ/ACK handshake. Before each byte it compares the phase lines driven by the target against the expected phase. A mismatch stops the command with an interrupt pulse, and nothing is transferred.

The I/O bit of the phase selects the direction. On inbound phases each byte is captured from the bus and presented to the sequencer. On outbound phases the engine drives a byte supplied by the sequencer and tells it when that byte has been consumed. Message phases get special treatment. ATN, once raised by a set command, drops together with the ACK of the final Message-Out byte. The ACK of the final Message-In byte stays asserted until the sequencer issues a clear command, so it can decide whether to reject the message first.

REQ and the phase lines arrive asynchronously and pass through a two-stage synchronizer before the control logic uses them.

Top module: `scsi_init_xfer`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_ack_o, bus_atn_o, bus_data_oe, busy, done, phase_irq, rx_valid and tx_take are all low.
- R2: Phase codes on {MSG, C/D, I/O} are 000 data-out, 001 data-in, 010 command, 011 status, 100/101 reserved, 110 message-out, 111 message-in. When bit 0 (I/O) is 0, the engine drives bus_data_o with bus_data_oe high from one cycle before ACK rises until ACK falls. When I/O is 1, bus_data_oe stays low.
- R3: When REQ is seen with phase lines that differ from the commanded phase, phase_irq pulses for one cycle, ACK is not asserted, busy drops and done is not given.
- R4: REQ and the phase lines pass through two synchronizing flops. ACK rises after synchronized REQ is seen high and falls in the cycle after synchronized REQ is seen low (except as in R9).
- R5: busy is high from the cycle after an accepted start until the command ends. done pulses for one cycle after the last byte. A start while busy is ignored.
- R6: A start with a count of zero gives done in the next cycle and performs no handshake.
- R7: set_atn raises bus_atn_o on the next cycle. On a message-out command, ATN falls in the same cycle ACK rises for the final byte, and stays up for earlier bytes.
- R8: If set_atn arrives in the cycle that would release ATN on the final message-out byte, ATN stays asserted.
- R9: After the final byte of a message-in command, bus_ack_o stays high with busy low until clr_ack, and falls the cycle after clr_ack. clr_ack with no held ACK has no effect.
- R10: Each inbound byte is presented on rx_data with a one-cycle rx_valid when it is captured. Each outbound byte gives a one-cycle tx_take after its ACK is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (ignored while busy) |
| cmd_phase | input | 3 | Expected phase {MSG, C/D, I/O} |
| cmd_count | input | CNT_W | Number of bytes to move |
| set_atn | input | 1 | Assert ATN |
| clr_ack | input | 1 | Release a held Message-In ACK |
| tx_data | input | 8 | Next outbound byte from the sequencer |
| tx_take | output | 1 | Outbound byte consumed |
| rx_data | output | 8 | Last inbound byte |
| rx_valid | output | 1 | rx_data updated |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command completed |
| phase_irq | output | 1 | Phase mismatch pulse |
| bus_req_i | input | 1 | REQ from target (asynchronous) |
| bus_phase_i | input | 3 | Phase lines from target (asynchronous) |
| bus_data_i | input | 8 | Bus data from target |
| bus_data_o | output | 8 | Bus data to target |
| bus_data_oe | output | 1 | Data bus drive enable |
| bus_ack_o | output | 1 | ACK to target |
| bus_atn_o | output | 1 | ATN to target |

## Verification
The ATN clear on the final message-out handshake and a sequencer set_atn can land on the same clock edge. The bench provokes this by watching for the single cycle in which the engine drives data while ACK is still low, the cycle just before the final ACK rises, and pulsing set_atn there. The expected result is that ACK rises while ATN stays high, and the cycle reference model encodes that set wins over the automatic release. The held Message-In ACK is also crossed with a stray clr_ack issued when nothing is held, to confirm that such a clear does nothing.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        PH_DATA_OUT = 3'b000,
        PH_DATA_IN  = 3'b001,
        PH_COMMAND  = 3'b010,
        PH_STATUS   = 3'b011,
        PH_RSV_OUT  = 3'b100,
        PH_RSV_IN   = 3'b101,
        PH_MSG_OUT  = 3'b110,
        PH_MSG_IN   = 3'b111
    } phase_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_DRIVE,
        ST_ACK
    } hs_state_t;

    // synchronized bus view
    typedef struct packed {
        logic   req;
        phase_t phase;
    } bus_view_t;

    function automatic logic is_inbound(phase_t p);
        return p[0];
    endfunction

endpackage

// File: rtl/xfer_sync.sv
module xfer_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic [W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/xfer_hs_fsm.sv
module xfer_hs_fsm
    import xfer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       cmd_phase,
    input  logic [CNT_W-1:0] cmd_count,
    input  bus_view_t        bus_s,
    input  logic [7:0]       tx_data,
    input  logic [7:0]       data_i,
    output logic             busy,
    output logic             done,
    output logic             phase_irq,
    output logic             ack_hs,
    output logic             data_oe,
    output logic [7:0]       data_o,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             tx_take,
    output logic             drop_atn,
    output logic             hold_set
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    hs_state_t        st;
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last     = (cnt == ONE);
    assign busy     = (st != ST_IDLE);
    assign ack_hs   = (st == ST_ACK);
    assign data_oe  = ((st == ST_DRIVE) || (st == ST_ACK)) && !is_inbound(ph);
    assign drop_atn = (st == ST_DRIVE) && last && (ph == PH_MSG_OUT);
    assign hold_set = (st == ST_ACK) && !bus_s.req && last && (ph == PH_MSG_IN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= PH_DATA_OUT;
            cnt       <= '0;
            data_o    <= '0;
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            done      <= 1'b0;
            phase_irq <= 1'b0;
            tx_take   <= 1'b0;
        end else begin
            rx_valid  <= 1'b0;
            done      <= 1'b0;
            phase_irq <= 1'b0;
            tx_take   <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        ph  <= phase_t'(cmd_phase);
                        cnt <= cmd_count;
                        if (cmd_count == '0) done <= 1'b1;
                        else                 st   <= ST_WAIT_REQ;
                    end
                end
                ST_WAIT_REQ: begin
                    if (bus_s.req) begin
                        if (bus_s.phase != ph) begin
                            phase_irq <= 1'b1;
                            st        <= ST_IDLE;
                        end else if (is_inbound(ph)) begin
                            rx_data  <= data_i;
                            rx_valid <= 1'b1;
                            st       <= ST_ACK;
                        end else begin
                            data_o <= tx_data;
                            st     <= ST_DRIVE;
                        end
                    end
                end
                ST_DRIVE: st <= ST_ACK;
                ST_ACK: begin
                    if (!bus_s.req) begin
                        tx_take <= !is_inbound(ph);
                        if (last) begin
                            done <= 1'b1;
                            st   <= ST_IDLE;
                        end else begin
                            cnt <= cnt - ONE;
                            st  <= ST_WAIT_REQ;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfer_atn_ack.sv
module xfer_atn_ack (
    input  logic clk,
    input  logic rst,
    input  logic set_atn,
    input  logic drop_atn,
    input  logic hold_set,
    input  logic clr_ack,
    input  logic ack_hs,
    output logic atn,
    output logic ack
);
    logic atn_q, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            atn_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            // a set request outranks the automatic release
            if (set_atn)       atn_q <= 1'b1;
            else if (drop_atn) atn_q <= 1'b0;
            if (hold_set)      hold_q <= 1'b1;
            else if (clr_ack)  hold_q <= 1'b0;
        end
    end

    assign atn = atn_q;
    assign ack = ack_hs | hold_q;
endmodule

// File: rtl/scsi_init_xfer.sv
module scsi_init_xfer
    import xfer_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       cmd_phase,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic             set_atn,
    input  logic             clr_ack,
    input  logic [7:0]       tx_data,
    output logic             tx_take,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             busy,
    output logic             done,
    output logic             phase_irq,
    input  logic             bus_req_i,
    input  logic [2:0]       bus_phase_i,
    input  logic [7:0]       bus_data_i,
    output logic [7:0]       bus_data_o,
    output logic             bus_data_oe,
    output logic             bus_ack_o,
    output logic             bus_atn_o
);
    localparam int VW = $bits(bus_view_t);

    bus_view_t bus_s;
    logic      ack_hs, drop_atn, hold_set;
    logic [VW-1:0] sync_q;

    xfer_sync #(.W(VW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_req_i, bus_phase_i}),
        .q   (sync_q)
    );
    assign bus_s = bus_view_t'(sync_q);

    xfer_hs_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cmd_phase (cmd_phase),
        .cmd_count (cmd_count),
        .bus_s     (bus_s),
        .tx_data   (tx_data),
        .data_i    (bus_data_i),
        .busy      (busy),
        .done      (done),
        .phase_irq (phase_irq),
        .ack_hs    (ack_hs),
        .data_oe   (bus_data_oe),
        .data_o    (bus_data_o),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .tx_take   (tx_take),
        .drop_atn  (drop_atn),
        .hold_set  (hold_set)
    );

    xfer_atn_ack u_ctl (
        .clk      (clk),
        .rst      (rst),
        .set_atn  (set_atn),
        .drop_atn (drop_atn),
        .hold_set (hold_set),
        .clr_ack  (clr_ack),
        .ack_hs   (ack_hs),
        .atn      (bus_atn_o),
        .ack      (bus_ack_o)
    );
endmodule

// File: rtl/scsi_init_xfer_chk.sv
module scsi_init_xfer_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic phase_irq,
    input logic bus_ack_o,
    input logic bus_atn_o,
    input logic bus_data_oe,
    input logic clr_ack
);
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_irq_not_done_r3: assert property (@(posedge clk) disable iff (rst)
        phase_irq |-> !done);

    p_ack_rise_busy_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack_o) |-> busy);

    p_atn_drop_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_atn_o) |-> $rose(bus_ack_o));

    p_held_ack_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_ack_o && !busy && !clr_ack) |=> bus_ack_o);

    p_drive_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> busy);
endmodule

bind scsi_init_xfer scsi_init_xfer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .phase_irq   (phase_irq),
    .bus_ack_o   (bus_ack_o),
    .bus_atn_o   (bus_atn_o),
    .bus_data_oe (bus_data_oe),
    .clr_ack     (clr_ack)
);

// File: tb/sim_scsi_init_xfer.sv
`timescale 1ns/1ps
module sim_scsi_init_xfer;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    cmd_phase = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          set_atn = 1'b0;
    logic          clr_ack = 1'b0;
    logic [7:0]    tx_data;
    logic          tx_take;
    logic [7:0]    rx_data;
    logic          rx_valid, busy, done, phase_irq;
    logic          bus_req_i = 1'b0;
    logic [2:0]    bus_phase_i = '0;
    logic [7:0]    bus_data_i = '0;
    logic [7:0]    bus_data_o;
    logic          bus_data_oe, bus_ack_o, bus_atn_o;

    always #5 clk = ~clk;

    scsi_init_xfer #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .start(start), .cmd_phase(cmd_phase),
        .cmd_count(cmd_count), .set_atn(set_atn), .clr_ack(clr_ack),
        .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data),
        .rx_valid(rx_valid), .busy(busy), .done(done), .phase_irq(phase_irq),
        .bus_req_i(bus_req_i), .bus_phase_i(bus_phase_i), .bus_data_i(bus_data_i),
        .bus_data_o(bus_data_o), .bus_data_oe(bus_data_oe),
        .bus_ack_o(bus_ack_o), .bus_atn_o(bus_atn_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // outbound byte source
    logic [7:0] tx_mem [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    int tx_idx = 0;
    assign tx_data = tx_mem[tx_idx];
    always @(negedge clk) if (!rst && tx_take) tx_idx++;

    // ---------------- cycle reference model ----------------
    int         ms = 0;          // 0 idle, 1 wait req, 2 drive, 3 ack
    int         mcnt = 0;
    logic [2:0] mph = '0;
    logic [3:0] m_s1 = '0, m_s2 = '0;
    logic [7:0] m_dout = '0, m_rxd = '0;
    logic       m_done = 0, m_irq = 0, m_rxv = 0, m_take = 0, m_atn = 0, m_hold = 0;

    always @(posedge clk) begin : mdl
        logic rq, dropnow, holdnow;
        logic [2:0] pq;
        if (rst) begin
            ms = 0; mcnt = 0; mph = '0; m_s1 = '0; m_s2 = '0;
            m_dout = '0; m_rxd = '0; m_done = 0; m_irq = 0; m_rxv = 0;
            m_take = 0; m_atn = 0; m_hold = 0;
        end else begin
            rq = m_s2[3];
            pq = m_s2[2:0];
            m_s2 = m_s1;
            m_s1 = {bus_req_i, bus_phase_i};
            dropnow = (ms == 2) && (mcnt == 1) && (mph == 3'b110);
            holdnow = (ms == 3) && !rq && (mcnt == 1) && (mph == 3'b111);
            m_done = 0; m_irq = 0; m_rxv = 0; m_take = 0;
            case (ms)
                0: if (start) begin
                    mph = cmd_phase; mcnt = int'(cmd_count);
                    if (cmd_count == 0) m_done = 1; else ms = 1;
                end
                1: if (rq) begin
                    if (pq != mph) begin m_irq = 1; ms = 0; end
                    else if (mph[0]) begin m_rxd = bus_data_i; m_rxv = 1; ms = 3; end
                    else begin m_dout = tx_data; ms = 2; end
                end
                2: ms = 3;
                default: if (!rq) begin
                    m_take = !mph[0];
                    if (mcnt == 1) begin m_done = 1; ms = 0; end
                    else begin mcnt = mcnt - 1; ms = 1; end
                end
            endcase
            if (set_atn) m_atn = 1; else if (dropnow) m_atn = 0;
            if (holdnow) m_hold = 1; else if (clr_ack) m_hold = 0;
        end
    end

    always @(negedge clk) begin
        logic e_oe;
        e_oe = ((ms == 2) || (ms == 3)) && !mph[0];
        chk(bus_ack_o, (ms == 3) || m_hold, "R4 ack");
        chk(bus_atn_o, m_atn, "R7 atn");
        chk(busy, ms != 0, "R5 busy");
        chk(done, m_done, "R5 done");
        chk(phase_irq, m_irq, "R3 irq");
        chk(bus_data_oe, e_oe, "R2 oe");
        if (e_oe) chk(bus_data_o, m_dout, "R2 data_o");
        chk(rx_valid, m_rxv, "R10 rx_valid");
        if (m_rxv) chk(rx_data, m_rxd, "R10 rx_data");
        chk(tx_take, m_take, "R10 tx_take");
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [2:0] ph, input int cnt);
        cmd_phase = ph; cmd_count = CW'(cnt); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_ack(input logic v);
        for (int n = 0; n < 60 && bus_ack_o !== v; n++) @(negedge clk);
    endtask

    task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] d, input bit keep, input bit collide);
        bus_phase_i = ph; bus_data_i = d;
        @(negedge clk);
        bus_req_i = 1'b1;
        for (int n = 0; n < 60 && bus_ack_o !== 1'b1; n++) begin
            set_atn = collide && bus_data_oe && !bus_ack_o;
            @(negedge clk);
        end
        set_atn = 1'b0;
        bus_req_i = 1'b0;
        if (!keep) wait_ack(1'b0);
        else repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk({bus_ack_o, bus_atn_o, bus_data_oe, busy, done, phase_irq, rx_valid, tx_take}, 0, "R1 reset");
        rst = 1'b0;
        @(negedge clk);
        chk({bus_ack_o, bus_atn_o, bus_data_oe, busy, done, phase_irq}, 0, "R1 after reset");

        // data-in, three bytes; a second start mid-transfer is ignored (R5)
        issue(3'b001, 3);
        tgt_byte(3'b001, 8'hA5, 0, 0);
        issue(3'b000, 9);
        tgt_byte(3'b001, 8'h3C, 0, 0);
        tgt_byte(3'b001, 8'hF0, 0, 0);
        repeat (2) @(negedge clk);
        chk(busy, 0, "R5 idle after three bytes");

        // data-out, two bytes (R2)
        issue(3'b000, 2);
        tgt_byte(3'b000, 8'h00, 0, 0);
        tgt_byte(3'b000, 8'h00, 0, 0);
        repeat (2) @(negedge clk);

        // R6: zero count
        issue(3'b010, 0);
        chk(done, 1, "R6 done on zero count");
        chk(busy, 0, "R6 no transfer");

        // R3: mismatch, target shows status while data-in expected
        issue(3'b001, 2);
        bus_phase_i = 3'b011;
        @(negedge clk);
        bus_req_i = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_ack_o, 0, "R3 no ack on mismatch");
        chk(busy, 0, "R3 command dropped");
        bus_req_i = 1'b0;
        repeat (3) @(negedge clk);

        // R7: message-out two bytes with ATN
        set_atn = 1'b1; @(negedge clk); set_atn = 1'b0;
        chk(bus_atn_o, 1, "R7 atn set");
        issue(3'b110, 2);
        tgt_byte(3'b110, 8'h00, 0, 0);
        chk(bus_atn_o, 1, "R7 atn kept before final byte");
        tgt_byte(3'b110, 8'h00, 0, 0);
        chk(bus_atn_o, 0, "R7 atn released on final byte");

        // R8: set_atn collides with final release
        issue(3'b110, 1);
        tgt_byte(3'b110, 8'h00, 0, 1);
        chk(bus_atn_o, 1, "R8 set wins over release");

        // R9: stray clear has no effect
        clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
        chk(bus_ack_o, 0, "R9 stray clear");

        // status byte then message-in two bytes with held ACK
        issue(3'b011, 1);
        tgt_byte(3'b011, 8'h02, 0, 0);
        issue(3'b111, 2);
        tgt_byte(3'b111, 8'h01, 0, 0);
        tgt_byte(3'b111, 8'h80, 1, 0);
        chk(bus_ack_o, 1, "R9 ack held");
        chk(busy, 0, "R9 idle while held");
        clr_ack = 1'b1; @(negedge clk); clr_ack = 1'b0;
        chk(bus_ack_o, 0, "R9 ack released by clear");
        repeat (4) @(negedge clk);
        wrap_up();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        wrap_up();
    end
endmodule